// File: doc/BRIEF.md
# Flash Write-Status Bit Generator

This block sits on the device side of a flash array. It builds the word a host reads back while an internal program or erase operation runs. The command decoder supplies the operation state: program active, erase active, erase suspended, and whether the addressed sector is the suspended one. From that state the block produces three status bits at fixed positions in the read word, and fills the remaining bits with array data. Bit 7 is the data-polling bit. Bit 6 is the main toggle. Bit 2 is the sector toggle.

Each completed read strobe registers one word onto the read bus. The same strobe then advances the toggle flip-flops that apply in the current mode. Bit 6 toggles during any active program or erase. Bit 2 toggles only where an erase touches the addressed sector, whether that erase is active or suspended. A host can therefore tell a sector under active erase from one that is erase-suspended.

The ready/busy output is open-drain and active-low. It is modelled here as the enable of the pull-down device: when the enable is high, the pin is held low. The `op_start` pulse marks the final write pulse of a command sequence, which is the 4th for a program and the 6th for an erase. Status is valid from that pulse onward.

Top module: `flash_wstat_gen`

## Requirements
- R1: After reset, `rd_data` is all zeros, the pull-down enable `rb_pull` is 0 (pin released), and the first status read of any operation returns bit 6 = 0 and bit 2 = 0.
- R2: While `prog_busy` is 1, a read returns bit 7 = NOT `prog_d7`, bit 2 = its held toggle value (no toggling), and every other bit except bit 6 equal to `array_data`.
- R3: During an active program or an active (unsuspended) erase, bit 6 inverts on each consecutive read strobe, starting from 0 after `op_start`.
- R4: While an erase is active (`erase_busy`=1, `erase_susp`=0, `prog_busy`=0), a read returns bit 7 = 0, bits 6 and 2 both alternating per read, and the other bits equal to `array_data`.
- R5: In erase-suspend (`erase_susp`=1, `prog_busy`=0) with `sect_hit`=1, a read returns bit 7 = 1 and bit 6 = 1, bit 2 alternates per read, and `rb_pull` is 0.
- R6: In erase-suspend with `sect_hit`=0 and no program, a read returns `array_data` on every bit and `rb_pull` is 0.
- R7: A program started during erase-suspend (`prog_busy`=1, `erase_susp`=1) returns bit 7 = NOT `prog_d7`, alternates bit 6, and holds `rb_pull` at 1.
- R8: Once no operation is active, reads return `array_data` on every bit; two consecutive reads of an unchanged location are identical (bit 6 stops toggling).
- R9: `rb_pull` is 1 exactly while a program is active or an erase is active and not suspended, otherwise 0. It follows the inputs in the same cycle.
- R10: `op_start` clears both toggle flip-flops, even when a read strobe occurs in the same cycle; the next read then returns bits 6 and 2 as 0 in any toggling mode.
- R11: `rd_data` changes only on the clock edge that samples `rd_strb`=1 and holds its value otherwise, whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_start | input | 1 | Pulse on the final write pulse of a program or erase command |
| prog_busy | input | 1 | Internal program in progress |
| erase_busy | input | 1 | Erase operation pending (active or suspended) |
| erase_susp | input | 1 | Erase currently suspended |
| sect_hit | input | 1 | Addressed sector is the erase-suspended one |
| prog_d7 | input | 1 | Bit 7 of the data being programmed |
| array_data | input | W | True array data at the read address |
| rd_strb | input | 1 | One-cycle pulse per completed read |
| rd_data | output | W | Registered read word |
| rb_pull | output | 1 | Open-drain pull-down enable of ready/busy (1 = pin low) |

## Verification
The hardest state to reach is a program that runs inside an erase-suspend window. It needs three overlapping conditions: an erase pending, the erase suspended, and a fresh program with its own `op_start`. After the program ends, the toggle history must still behave correctly. The bench builds this state in order: it starts an erase, reads several times, suspends, reads both sector kinds, and then launches the nested program. It then clears the program, resumes the erase, and checks that toggling continues from the bench's own model of the toggle state.

// File: rtl/wsg_pkg.sv
// Package: shared mode type and status-bit positions for the write-status
// generator. Assumes a read word of at least 8 bits.
package wsg_pkg;
    typedef enum logic [2:0] {
        M_IDLE      = 3'd0,
        M_PROG      = 3'd1,
        M_ERASE     = 3'd2,
        M_SUSP_HIT  = 3'd3,
        M_SUSP_MISS = 3'd4
    } wsg_mode_e;

    localparam int POLL_BIT = 7;
    localparam int TGL_BIT  = 6;
    localparam int SECT_BIT = 2;
endpackage

// File: rtl/wsg_mode_dec.sv
// Module: wsg_mode_dec
// Decodes the operation-state inputs into one mode and the busy indication.
// A program always wins, so a program nested in erase-suspend is reported
// as a program. Assumes the inputs are stable, synchronous levels.
module wsg_mode_dec
    import wsg_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      prog_busy,
    input  logic      erase_busy,
    input  logic      erase_susp,
    input  logic      sect_hit,
    output wsg_mode_e mode,
    output logic      busy
);
    // Priority decode of the current operation mode
    always_comb begin
        if (prog_busy)
            mode = M_PROG;
        else if (erase_busy && !erase_susp)
            mode = M_ERASE;
        else if (erase_susp && sect_hit)
            mode = M_SUSP_HIT;
        else if (erase_susp)
            mode = M_SUSP_MISS;
        else
            mode = M_IDLE;
    end

    // Busy while the array is being actively written
    always_comb busy = (mode == M_PROG) || (mode == M_ERASE);

    // R9 / R7: a running program always reports busy
    a_r7_prog_busy: assert property (@(posedge clk) disable iff (!rst_n)
        prog_busy |-> busy);
    // R9 / R5: a suspended erase without a program never reports busy
    a_r9_susp_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (erase_susp && !prog_busy) |-> !busy);
endmodule

// File: rtl/wsg_toggle.sv
// Module: wsg_toggle
// Holds the two toggle flip-flops. Each one flips on a completed read strobe
// in the modes where it is defined to toggle. A new operation (op_start)
// clears both, and the clear takes priority over a same-cycle strobe.
module wsg_toggle
    import wsg_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      op_start,
    input  logic      rd_strb,
    input  wsg_mode_e mode,
    output logic      tgl6,
    output logic      tgl2
);
    logic flip6, flip2;

    // Modes in which each toggle advances
    always_comb begin
        flip6 = (mode == M_PROG) || (mode == M_ERASE);
        flip2 = (mode == M_ERASE) || (mode == M_SUSP_HIT);
    end

    // Toggle state update: reset/clear first, then flip on a read
    always_ff @(posedge clk) begin
        if (!rst_n || op_start) begin
            tgl6 <= 1'b0;
            tgl2 <= 1'b0;
        end else if (rd_strb) begin
            if (flip6) tgl6 <= ~tgl6;
            if (flip2) tgl2 <= ~tgl2;
        end
    end

    // R10: a new operation leaves both toggles cleared
    a_r10_clear: assert property (@(posedge clk) disable iff (!rst_n)
        op_start |=> (!tgl6 && !tgl2));
    // R3: a read in an active operation inverts the main toggle
    a_r3_flip: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_strb && !op_start && (mode == M_PROG || mode == M_ERASE))
            |=> (tgl6 != $past(tgl6)));
    // R8: with no operation, reads leave the main toggle unchanged
    a_r8_no_toggle: assert property (@(posedge clk) disable iff (!rst_n)
        (!op_start && mode == M_IDLE) |=> $stable(tgl6));
endmodule

// File: rtl/wsg_word_mux.sv
// Module: wsg_word_mux
// Builds the status word for the current mode and registers it on a read
// strobe. The word uses the toggle values before the flip of the same strobe.
// Bits other than 7, 6 and 2 always carry array data.
module wsg_word_mux
    import wsg_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         rd_strb,
    input  wsg_mode_e    mode,
    input  logic         tgl6,
    input  logic         tgl2,
    input  logic         prog_d7,
    input  logic [W-1:0] array_data,
    output logic [W-1:0] rd_data
);
    logic [W-1:0] word;

    // Overlay the status bits that apply in the current mode
    always_comb begin
        word = array_data;
        case (mode)
            M_PROG: begin
                word[POLL_BIT] = ~prog_d7;
                word[TGL_BIT]  = tgl6;
                word[SECT_BIT] = tgl2;
            end
            M_ERASE: begin
                word[POLL_BIT] = 1'b0;
                word[TGL_BIT]  = tgl6;
                word[SECT_BIT] = tgl2;
            end
            M_SUSP_HIT: begin
                word[POLL_BIT] = 1'b1;
                word[TGL_BIT]  = 1'b1;
                word[SECT_BIT] = tgl2;
            end
            default: word = array_data;
        endcase
    end

    // Read register: captures the word on a completed read
    always_ff @(posedge clk) begin
        if (!rst_n)
            rd_data <= '0;
        else if (rd_strb)
            rd_data <= word;
    end

    // R11: without a strobe the read bus holds
    a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_strb |=> $stable(rd_data));
    // R5: a suspended-sector read shows both polling and main toggle high
    a_r5_susp_hit: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_strb && mode == M_SUSP_HIT) |=> (rd_data[POLL_BIT] && rd_data[TGL_BIT]));
    // R4: an active-erase read shows the polling bit low
    a_r4_erase_poll: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_strb && mode == M_ERASE) |=> !rd_data[POLL_BIT]);
endmodule

// File: rtl/flash_wstat_gen.sv
// Module: flash_wstat_gen (top)
// Status-word generator for a flash array during internal program/erase.
// Assumes op_start pulses on the final write pulse of each command, and that
// rd_strb is a single-cycle pulse per completed read. W must be at least 8.
module flash_wstat_gen
    import wsg_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         op_start,
    input  logic         prog_busy,
    input  logic         erase_busy,
    input  logic         erase_susp,
    input  logic         sect_hit,
    input  logic         prog_d7,
    input  logic [W-1:0] array_data,
    input  logic         rd_strb,
    output logic [W-1:0] rd_data,
    output logic         rb_pull
);
    wsg_mode_e mode;
    logic      busy;
    logic      tgl6, tgl2;

    // Width guard: the status bits need at least 8 data bits
    generate
        if (W < 8) begin : g_bad_width
            $error("flash_wstat_gen: W must be at least 8");
        end
    endgenerate

    wsg_mode_dec u_dec (
        .clk        (clk),
        .rst_n      (rst_n),
        .prog_busy  (prog_busy),
        .erase_busy (erase_busy),
        .erase_susp (erase_susp),
        .sect_hit   (sect_hit),
        .mode       (mode),
        .busy       (busy)
    );

    wsg_toggle u_tgl (
        .clk      (clk),
        .rst_n    (rst_n),
        .op_start (op_start),
        .rd_strb  (rd_strb),
        .mode     (mode),
        .tgl6     (tgl6),
        .tgl2     (tgl2)
    );

    wsg_word_mux #(.W(W)) u_mux (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_strb    (rd_strb),
        .mode       (mode),
        .tgl6       (tgl6),
        .tgl2       (tgl2),
        .prog_d7    (prog_d7),
        .array_data (array_data),
        .rd_data    (rd_data)
    );

    // Open-drain pull-down enable follows the busy decode
    always_comb rb_pull = busy;

    // R9: an active, unsuspended erase holds the pin low
    a_r9_erase_low: assert property (@(posedge clk) disable iff (!rst_n)
        (erase_busy && !erase_susp) |-> rb_pull);
    // R9: with nothing pending the pin is released
    a_r9_idle_rel: assert property (@(posedge clk) disable iff (!rst_n)
        (!prog_busy && !erase_busy) |-> !rb_pull);
endmodule

// File: tb/flash_wstat_gen_test.sv
// Directed bench for flash_wstat_gen: one task per scenario, each checking
// its own results against values derived from the requirements.
module flash_wstat_gen_test;
    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         op_start = 1'b0;
    logic         prog_busy = 1'b0;
    logic         erase_busy = 1'b0;
    logic         erase_susp = 1'b0;
    logic         sect_hit = 1'b0;
    logic         prog_d7 = 1'b0;
    logic [W-1:0] array_data = '0;
    logic         rd_strb = 1'b0;
    logic [W-1:0] rd_data;
    logic         rb_pull;

    int n_chk = 0;
    int n_bad = 0;
    bit e6 = 1'b0;
    bit e2 = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    flash_wstat_gen #(.W(W)) uut (
        .clk(clk), .rst_n(rst_n), .op_start(op_start), .prog_busy(prog_busy),
        .erase_busy(erase_busy), .erase_susp(erase_susp), .sect_hit(sect_hit),
        .prog_d7(prog_d7), .array_data(array_data), .rd_strb(rd_strb),
        .rd_data(rd_data), .rb_pull(rb_pull)
    );

    task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [W-1:0] ovl(input logic [W-1:0] a, input bit b7, input bit b6, input bit b2);
        logic [W-1:0] r = a;
        r[7] = b7; r[6] = b6; r[2] = b2;
        return r;
    endfunction

    // One read: strobe for one cycle, sample the cycle after; flip model toggles
    task automatic rd(output logic [W-1:0] d, input bit f6, input bit f2);
        @(negedge clk) rd_strb = 1'b1;
        @(negedge clk) rd_strb = 1'b0;
        d = rd_data;
        if (f6) e6 = ~e6;
        if (f2) e2 = ~e2;
    endtask

    task automatic start_op();
        @(negedge clk) op_start = 1'b1;
        @(negedge clk) op_start = 1'b0;
        e6 = 1'b0; e2 = 1'b0;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check("R1 rd_data", rd_data, '0);
        check("R1 rb_pull", {15'd0, rb_pull}, 16'd0);
    endtask

    task automatic t_program();
        logic [W-1:0] d;
        array_data = 16'h1234; prog_d7 = 1'b1;
        start_op();
        @(negedge clk) prog_busy = 1'b1;
        #1 check("R9 program busy", {15'd0, rb_pull}, 16'd1);
        for (int i = 0; i < 4; i++) begin
            logic b6 = e6;
            logic b2 = e2;
            rd(d, 1'b1, 1'b0);
            check("R2/R3 program read", d, ovl(16'h1234, 1'b0, b6, b2));
        end
        check("R2 bit2 held", {15'd0, e2}, 16'd0);
        @(negedge clk) prog_busy = 1'b0; array_data = 16'h12B4;
        rd(d, 1'b0, 1'b0);
        check("R8 program done", d, 16'h12B4);
        check("R9 released", {15'd0, rb_pull}, 16'd0);
    endtask

    task automatic t_erase_suspend();
        logic [W-1:0] d;
        array_data = 16'h0F0F;
        start_op();
        @(negedge clk) erase_busy = 1'b1;
        for (int i = 0; i < 3; i++) begin
            logic b6 = e6;
            logic b2 = e2;
            rd(d, 1'b1, 1'b1);
            check("R4 erase read", d, ovl(16'h0F0F, 1'b0, b6, b2));
        end
        @(negedge clk) erase_susp = 1'b1; sect_hit = 1'b1; array_data = 16'hA5A5;
        #1 check("R5 ready in suspend", {15'd0, rb_pull}, 16'd0);
        for (int i = 0; i < 2; i++) begin
            logic b2 = e2;
            rd(d, 1'b0, 1'b1);
            check("R5 suspended sector", d, ovl(16'hA5A5, 1'b1, 1'b1, b2));
        end
        @(negedge clk) sect_hit = 1'b0; array_data = 16'h3C7E;
        rd(d, 1'b0, 1'b0);
        check("R6 other sector", d, 16'h3C7E);
        check("R6 ready", {15'd0, rb_pull}, 16'd0);
        // R7: nested program during suspend
        prog_d7 = 1'b0; array_data = 16'h0055;
        start_op();
        @(negedge clk) prog_busy = 1'b1;
        #1 check("R7 busy", {15'd0, rb_pull}, 16'd1);
        for (int i = 0; i < 3; i++) begin
            logic b6 = e6;
            logic b2 = e2;
            rd(d, 1'b1, 1'b0);
            check("R7 nested program", d, ovl(16'h0055, 1'b1, b6, b2));
        end
        // Resume the erase and let it finish
        @(negedge clk) prog_busy = 1'b0; erase_susp = 1'b0; array_data = 16'h0000;
        for (int i = 0; i < 2; i++) begin
            logic b6 = e6;
            logic b2 = e2;
            rd(d, 1'b1, 1'b1);
            check("R4 resumed erase", d, ovl(16'h0000, 1'b0, b6, b2));
        end
        @(negedge clk) erase_busy = 1'b0; array_data = 16'hFFFF;
        rd(d, 1'b0, 1'b0);
        check("R8 erase done first", d, 16'hFFFF);
        rd(d, 1'b0, 1'b0);
        check("R8 erase done second", d, 16'hFFFF);
    endtask

    task automatic t_clear_and_hold();
        logic [W-1:0] d;
        array_data = 16'h00F0;
        start_op();
        @(negedge clk) erase_busy = 1'b1;
        rd(d, 1'b1, 1'b1);
        // op_start and strobe in the same cycle: clear wins
        @(negedge clk) op_start = 1'b1; rd_strb = 1'b1;
        @(negedge clk) op_start = 1'b0; rd_strb = 1'b0;
        e6 = 1'b0; e2 = 1'b0;
        rd(d, 1'b1, 1'b1);
        check("R10 cleared toggles", d, ovl(16'h00F0, 1'b0, 1'b0, 1'b0));
        // R11: inputs change without a strobe; bus must hold
        @(negedge clk) erase_busy = 1'b0; array_data = 16'hBEEF;
        repeat (3) @(negedge clk);
        check("R11 hold", rd_data, ovl(16'h00F0, 1'b0, 1'b0, 1'b0));
        rd(d, 1'b0, 1'b0);
        check("R11 update on strobe", d, 16'hBEEF);
    endtask

    initial begin
        t_reset();
        t_program();
        t_erase_suspend();
        t_clear_and_hold();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #2000000;
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule